// File: doc/BRIEF.md
# DSP Processing Element

A compact signal-processing engine meant to sit in a row of identical elements under a host. It owns a 1024-word instruction store, a 1024-word data store, eight 16-bit general registers and a 40-bit accumulator. Once the host has loaded a program it writes a start bit. The element then executes one instruction per clock from address 0 until it reaches a halt, hits an undefined opcode, or the host stops it.

The instruction set is small and DSP-oriented. It has a four-operand dual multiply-add into the accumulator, a multiply-add that takes its addend from the neighbouring element's accumulator, and a move out of the accumulator with 16-bit saturation. It also has loads, stores, an add and a small immediate load. The raw, unsaturated accumulator is driven out at all times, so one element can seed the next and 8-tap filter segments can be chained into longer filters. Every result written in the execute stage is also published on a result bus for other elements to observe.

All host traffic goes through one word-wide port. Address bits [11:10] select the space: 0 is control/registers, 1 is instruction store, 2 is data store. While the element is halted the host can read and write every architectural register and memory word.

Top module: `dsp_pe`

## Requirements
- R1: After a synchronous active-low reset, `running`, `done`, `error` and `res_valid` are 0, `acc_out` is 0, the program counter reads 0 and all eight registers read 0.
- R2: While halted, the host accesses state through `host_addr`, and `host_rdata` reflects the addressed state in the same cycle. In space 0, index 0 is status {error,done,running} in bits [2:0], index 1 is the PC, index 2 is accumulator bits [31:0], index 3 is accumulator bits [39:32], and indices 8..15 are registers r0..r7, zero-extended. Space 1 is instruction words and space 2 is data words, indexed by `host_addr[9:0]`. A write takes effect at the clock edge that samples it.
- R3: While `running` is 1, host writes to registers, accumulator, instruction store and data store are ignored.
- R4: Writing 1 to bit 0 of control index 0 sets the PC to 0, clears `done` and `error`, and sets `running`. The element then executes one instruction per cycle. The instruction word is opcode [31:24], ra [23:21], rb [20:18], rc [17:15], rd [14:12], imm [11:0]. HALT (0xFF) clears `running`, sets `done`, and leaves the PC at the HALT address. NOP is 0x00.
- R5: ADD (0x01) writes rf[rb]+rf[rc] to rf[ra], wrapping modulo 2^16. LDI (0x08) writes imm sign-extended to 16 bits into rf[ra].
- R6: DMA (0x02) adds rf[ra]*rf[rb] + rf[rc]*rf[rd] to the accumulator. Operands and products are signed, and products are sign-extended to 40 bits, with the sum wrapping modulo 2^40. CLRA (0x07) zeroes the accumulator.
- R7: MACC (0x03) loads the accumulator with `chain_in` + rf[ra]*rf[rb], with a signed product.
- R8: MVA (0x06) writes the accumulator saturated to the range -32768..32767 into rf[ra].
- R9: ST (0x05) writes rf[ra] to data word imm[9:0]. LD (0x04) writes data word imm[9:0] into rf[ra].
- R10: Any other opcode clears `running`, sets `error` and leaves `done` at 0. `error` stays set until the next start.
- R11: `acc_out` always equals the accumulator. Each executed ADD, LDI, LD, MVA, DMA, MACC or CLRA drives `res_valid` high on the cycle after the edge that executed it. It also puts on `res_bus` the written register value, sign-extended, or the new accumulator.
- R12: Writing 1 to bit 1 of control index 0 clears `running` without setting `done`. If start and stop are written together, stop wins for `running`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 12 | Host space [11:10] and index [9:0] |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for the addressed state |
| chain_in | input | 40 | Accumulator from the preceding element |
| acc_out | output | 40 | Unsaturated accumulator to the next element |
| res_valid | output | 1 | Result bus holds a fresh execute result |
| res_bus | output | 40 | Execute-stage result |
| running | output | 1 | Element is executing |
| done | output | 1 | Program reached HALT |
| error | output | 1 | Undefined opcode seen (sticky) |

## Verification
Host reads are combinational, so the bench samples `host_rdata` two nanoseconds after driving the address, within the same low phase. A host write, or an instruction executing at clock edge N, becomes visible in registers, accumulator and flags right after edge N. `res_valid`/`res_bus` follow the same edge, one cycle after the instruction was fetched. A behavioural instruction model in the bench advances on every rising edge from the same inputs. The outputs are compared 3 ns after each edge, and directed host reads confirm hand-computed register and accumulator values once each program halts.

// File: rtl/dsp_pe_pkg.sv
// Shared widths, instruction layout, opcodes and the saturation helper for
// the DSP processing element. Assumes 16-bit data and a 40-bit accumulator.
package dsp_pe_pkg;

    localparam int DATA_W  = 16;
    localparam int ACC_W   = 40;
    localparam int INSTR_W = 32;
    localparam int HOST_W  = 32;
    localparam int NUM_REG = 8;
    localparam int REG_IW  = $clog2(NUM_REG);
    localparam int IMM_W   = INSTR_W - 8 - 4 * REG_IW;

    typedef enum logic [7:0] {
        OP_NOP  = 8'h00,
        OP_ADD  = 8'h01,
        OP_DMA  = 8'h02,
        OP_MACC = 8'h03,
        OP_LD   = 8'h04,
        OP_ST   = 8'h05,
        OP_MVA  = 8'h06,
        OP_CLRA = 8'h07,
        OP_LDI  = 8'h08,
        OP_HALT = 8'hFF
    } opcode_e;

    typedef struct packed {
        logic [7:0]        op;
        logic [REG_IW-1:0] ra;
        logic [REG_IW-1:0] rb;
        logic [REG_IW-1:0] rc;
        logic [REG_IW-1:0] rd;
        logic [IMM_W-1:0]  imm;
    } instr_t;

    // Clamp a signed accumulator value to the signed 16-bit range.
    function automatic logic [DATA_W-1:0] sat_to_data(input logic signed [ACC_W-1:0] v);
        logic signed [ACC_W-1:0] hi;
        logic signed [ACC_W-1:0] lo;
        hi = ACC_W'((1 << (DATA_W - 1)) - 1);
        lo = -ACC_W'(1 << (DATA_W - 1));
        if (v > hi)      return {1'b0, {(DATA_W-1){1'b1}}};
        else if (v < lo) return {1'b1, {(DATA_W-1){1'b0}}};
        else             return v[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/pe_mem.sv
// Word-addressed storage with one synchronous write port and two
// combinational read ports. Contents are not reset; software loads them.
module pe_mem #(
    parameter int DEPTH = 1024,
    parameter int WIDTH = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [WIDTH-1:0]  rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [WIDTH-1:0]  rdata_b
);

    logic [WIDTH-1:0] cells [DEPTH];

    // Store one word per cycle when enabled.
    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata_a = cells[raddr_a];
    assign rdata_b = cells[raddr_b];

endmodule

// File: rtl/pe_regfile.sv
// General register file: NREG words, NRD execute read ports, one host read
// port, and two write ports (execute, host). The two writers are expected to
// be mutually exclusive; execute wins if both arrive.
module pe_regfile #(
    parameter int NREG  = 8,
    parameter int WIDTH = 16,
    parameter int NRD   = 4,
    parameter int RI    = $clog2(NREG)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       exec_we,
    input  logic [RI-1:0]              exec_waddr,
    input  logic [WIDTH-1:0]           exec_wdata,
    input  logic                       host_we,
    input  logic [RI-1:0]              host_waddr,
    input  logic [WIDTH-1:0]           host_wdata,
    input  logic [NRD-1:0][RI-1:0]     raddr,
    output logic [NRD-1:0][WIDTH-1:0]  rdata,
    input  logic [RI-1:0]              host_raddr,
    output logic [WIDTH-1:0]           host_rdata
);

    logic [WIDTH-1:0] regs [NREG];

    // Clear on reset, then accept one write per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (exec_we) begin
            regs[exec_waddr] <= exec_wdata;
        end else if (host_we) begin
            regs[host_waddr] <= host_wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = regs[raddr[p]];
    end

    assign host_rdata = regs[host_raddr];

    assert_rf_one_writer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(exec_we && host_we));

endmodule

// File: rtl/pe_exec.sv
// Combinational decode and datapath for one instruction. It produces
// write-back requests that the top gates with the running state.
module pe_exec
    import dsp_pe_pkg::*;
#(
    parameter int DM_AW = 10
) (
    input  instr_t                         instr,
    input  logic [3:0][DATA_W-1:0]         rs,
    input  logic [ACC_W-1:0]               acc,
    input  logic [ACC_W-1:0]               chain,
    input  logic [DATA_W-1:0]              dm_rdata,
    output logic                           rf_we,
    output logic [REG_IW-1:0]              rf_waddr,
    output logic [DATA_W-1:0]              rf_wdata,
    output logic                           acc_we,
    output logic [ACC_W-1:0]               acc_next,
    output logic                           dm_we,
    output logic [DM_AW-1:0]               dm_addr,
    output logic [DATA_W-1:0]              dm_wdata,
    output logic                           halt,
    output logic                           illegal,
    output logic                           res_valid,
    output logic [ACC_W-1:0]               res
);

    localparam int PROD_W = 2 * DATA_W;

    logic signed [PROD_W-1:0] prod_a;
    logic signed [PROD_W-1:0] prod_b;
    logic [ACC_W-1:0]         prod_a_x;
    logic [ACC_W-1:0]         prod_b_x;

    // Two signed products, sign-extended to accumulator width.
    always_comb begin
        prod_a   = $signed(rs[0]) * $signed(rs[1]);
        prod_b   = $signed(rs[2]) * $signed(rs[3]);
        prod_a_x = {{(ACC_W-PROD_W){prod_a[PROD_W-1]}}, prod_a};
        prod_b_x = {{(ACC_W-PROD_W){prod_b[PROD_W-1]}}, prod_b};
    end

    // Decode the opcode and form every write-back request.
    always_comb begin
        rf_we     = 1'b0;
        rf_waddr  = instr.ra;
        rf_wdata  = '0;
        acc_we    = 1'b0;
        acc_next  = acc;
        dm_we     = 1'b0;
        dm_addr   = instr.imm[DM_AW-1:0];
        dm_wdata  = rs[0];
        halt      = 1'b0;
        illegal   = 1'b0;
        case (opcode_e'(instr.op))
            OP_NOP: ;
            OP_ADD: begin
                rf_we    = 1'b1;
                rf_wdata = rs[1] + rs[2];
            end
            OP_LDI: begin
                rf_we    = 1'b1;
                rf_wdata = {{(DATA_W-IMM_W){instr.imm[IMM_W-1]}}, instr.imm};
            end
            OP_LD: begin
                rf_we    = 1'b1;
                rf_wdata = dm_rdata;
            end
            OP_ST:   dm_we = 1'b1;
            OP_MVA: begin
                rf_we    = 1'b1;
                rf_wdata = sat_to_data(acc);
            end
            OP_DMA: begin
                acc_we   = 1'b1;
                acc_next = acc + prod_a_x + prod_b_x;
            end
            OP_MACC: begin
                acc_we   = 1'b1;
                acc_next = chain + prod_a_x;
            end
            OP_CLRA: begin
                acc_we   = 1'b1;
                acc_next = '0;
            end
            OP_HALT: halt = 1'b1;
            default: illegal = 1'b1;
        endcase
        res_valid = rf_we | acc_we;
        res       = acc_we ? acc_next
                           : {{(ACC_W-DATA_W){rf_wdata[DATA_W-1]}}, rf_wdata};
    end

endmodule

// File: rtl/pe_ctrl.sv
// Run sequencer: program counter, running/done/error flags. Start resets
// the PC and flags; stop has priority over start for the running flag.
module pe_ctrl #(
    parameter int PC_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            stop,
    input  logic            halt,
    input  logic            illegal,
    output logic            running,
    output logic            done,
    output logic            err,
    output logic [PC_W-1:0] pc
);

    // Advance, halt or trap, then apply host control on top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            done    <= 1'b0;
            err     <= 1'b0;
            pc      <= '0;
        end else begin
            if (running) begin
                if (illegal) begin
                    running <= 1'b0;
                    err     <= 1'b1;
                end else if (halt) begin
                    running <= 1'b0;
                    done    <= 1'b1;
                end else begin
                    pc <= pc + 1'b1;
                end
            end
            if (start) begin
                pc      <= '0;
                running <= 1'b1;
                done    <= 1'b0;
                err     <= 1'b0;
            end
            if (stop) running <= 1'b0;
        end
    end

    assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !start) |=> err);

    assert_pc_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !halt && !illegal && !start) |=> (pc == PC_W'($past(pc) + 1'b1)));

    assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !running);

endmodule

// File: rtl/dsp_pe.sv
// DSP processing element top: host decode, instruction and data stores,
// register file, accumulator and result bus. One instruction per cycle
// while running; host writes to state are accepted only while halted.
module dsp_pe
    import dsp_pe_pkg::*;
#(
    parameter int IMEM_DEPTH = 1024,
    parameter int DMEM_DEPTH = 1024,
    parameter int HOST_AW    = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_we,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [HOST_W-1:0]  host_wdata,
    output logic [HOST_W-1:0]  host_rdata,
    input  logic [ACC_W-1:0]   chain_in,
    output logic [ACC_W-1:0]   acc_out,
    output logic               res_valid,
    output logic [ACC_W-1:0]   res_bus,
    output logic               running,
    output logic               done,
    output logic               error
);

    localparam int IM_AW    = $clog2(IMEM_DEPTH);
    localparam int DM_AW    = $clog2(DMEM_DEPTH);
    localparam int HIDX_W   = HOST_AW - 2;
    localparam int REG_BASE = NUM_REG;
    localparam logic [1:0] SP_CTL = 2'd0;
    localparam logic [1:0] SP_IM  = 2'd1;
    localparam logic [1:0] SP_DM  = 2'd2;

    // Host decode
    logic [1:0]        h_space;
    logic [HIDX_W-1:0] h_idx;
    logic              h_ctl_wr;
    logic              h_start;
    logic              h_stop;
    logic              h_is_reg;
    logic              h_state_wr;

    assign h_space    = host_addr[HOST_AW-1:HOST_AW-2];
    assign h_idx      = host_addr[HIDX_W-1:0];
    assign h_ctl_wr   = host_we && (h_space == SP_CTL);
    assign h_start    = h_ctl_wr && (h_idx == '0) && host_wdata[0];
    assign h_stop     = h_ctl_wr && (h_idx == '0) && host_wdata[1];
    assign h_is_reg   = (int'(h_idx) >= REG_BASE) && (int'(h_idx) < REG_BASE + NUM_REG);
    assign h_state_wr = host_we && !running;

    // Control
    logic [IM_AW-1:0] pc;
    logic             x_halt;
    logic             x_illegal;

    pe_ctrl #(.PC_W(IM_AW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (h_start),
        .stop    (h_stop),
        .halt    (x_halt),
        .illegal (x_illegal),
        .running (running),
        .done    (done),
        .err     (error),
        .pc      (pc)
    );

    // Instruction store
    logic [INSTR_W-1:0] im_fetch;
    logic [INSTR_W-1:0] im_host_rd;
    instr_t             instr;

    pe_mem #(.DEPTH(IMEM_DEPTH), .WIDTH(INSTR_W)) u_imem (
        .clk     (clk),
        .we      (h_state_wr && (h_space == SP_IM)),
        .waddr   (h_idx[IM_AW-1:0]),
        .wdata   (host_wdata[INSTR_W-1:0]),
        .raddr_a (pc),
        .rdata_a (im_fetch),
        .raddr_b (h_idx[IM_AW-1:0]),
        .rdata_b (im_host_rd)
    );

    assign instr = instr_t'(im_fetch);

    // Register file
    logic [3:0][REG_IW-1:0] rf_raddr;
    logic [3:0][DATA_W-1:0] rf_rdata;
    logic [DATA_W-1:0]      rf_host_rd;
    logic                   x_rf_we;
    logic [REG_IW-1:0]      x_rf_waddr;
    logic [DATA_W-1:0]      x_rf_wdata;

    assign rf_raddr[0] = instr.ra;
    assign rf_raddr[1] = instr.rb;
    assign rf_raddr[2] = instr.rc;
    assign rf_raddr[3] = instr.rd;

    pe_regfile #(.NREG(NUM_REG), .WIDTH(DATA_W), .NRD(4)) u_rf (
        .clk        (clk),
        .rst_n      (rst_n),
        .exec_we    (running && x_rf_we),
        .exec_waddr (x_rf_waddr),
        .exec_wdata (x_rf_wdata),
        .host_we    (h_state_wr && (h_space == SP_CTL) && h_is_reg),
        .host_waddr (h_idx[REG_IW-1:0]),
        .host_wdata (host_wdata[DATA_W-1:0]),
        .raddr      (rf_raddr),
        .rdata      (rf_rdata),
        .host_raddr (h_idx[REG_IW-1:0]),
        .host_rdata (rf_host_rd)
    );

    // Data store, execute port has the write port while running
    logic              x_dm_we;
    logic [DM_AW-1:0]  x_dm_addr;
    logic [DATA_W-1:0] x_dm_wdata;
    logic [DATA_W-1:0] dm_exec_rd;
    logic [DATA_W-1:0] dm_host_rd;
    logic              dm_we;
    logic [DM_AW-1:0]  dm_waddr;
    logic [DATA_W-1:0] dm_wdata;

    assign dm_we    = running ? x_dm_we : (h_state_wr && (h_space == SP_DM));
    assign dm_waddr = running ? x_dm_addr : h_idx[DM_AW-1:0];
    assign dm_wdata = running ? x_dm_wdata : host_wdata[DATA_W-1:0];

    pe_mem #(.DEPTH(DMEM_DEPTH), .WIDTH(DATA_W)) u_dmem (
        .clk     (clk),
        .we      (dm_we),
        .waddr   (dm_waddr),
        .wdata   (dm_wdata),
        .raddr_a (x_dm_addr),
        .rdata_a (dm_exec_rd),
        .raddr_b (h_idx[DM_AW-1:0]),
        .rdata_b (dm_host_rd)
    );

    // Execute
    logic [ACC_W-1:0] acc_q;
    logic             x_acc_we;
    logic [ACC_W-1:0] x_acc_next;
    logic             x_res_valid;
    logic [ACC_W-1:0] x_res;

    pe_exec #(.DM_AW(DM_AW)) u_exec (
        .instr     (instr),
        .rs        (rf_rdata),
        .acc       (acc_q),
        .chain     (chain_in),
        .dm_rdata  (dm_exec_rd),
        .rf_we     (x_rf_we),
        .rf_waddr  (x_rf_waddr),
        .rf_wdata  (x_rf_wdata),
        .acc_we    (x_acc_we),
        .acc_next  (x_acc_next),
        .dm_we     (x_dm_we),
        .dm_addr   (x_dm_addr),
        .dm_wdata  (x_dm_wdata),
        .halt      (x_halt),
        .illegal   (x_illegal),
        .res_valid (x_res_valid),
        .res       (x_res)
    );

    logic h_acc_lo_wr;
    logic h_acc_hi_wr;
    assign h_acc_lo_wr = h_state_wr && (h_space == SP_CTL) && (int'(h_idx) == 2);
    assign h_acc_hi_wr = h_state_wr && (h_space == SP_CTL) && (int'(h_idx) == 3);

    // Accumulator: execute update, else host halves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (running && x_acc_we) begin
            acc_q <= x_acc_next;
        end else if (h_acc_lo_wr) begin
            acc_q[HOST_W-1:0] <= host_wdata;
        end else if (h_acc_hi_wr) begin
            acc_q[ACC_W-1:HOST_W] <= host_wdata[ACC_W-HOST_W-1:0];
        end
    end

    // Result bus: register the execute-stage result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_bus   <= '0;
        end else begin
            res_valid <= running && x_res_valid;
            if (running && x_res_valid) res_bus <= x_res;
        end
    end

    assign acc_out = acc_q;

    // Host read mux.
    always_comb begin
        host_rdata = '0;
        case (h_space)
            SP_CTL: begin
                if (int'(h_idx) == 0)      host_rdata = HOST_W'({error, done, running});
                else if (int'(h_idx) == 1) host_rdata = HOST_W'(pc);
                else if (int'(h_idx) == 2) host_rdata = acc_q[HOST_W-1:0];
                else if (int'(h_idx) == 3) host_rdata = HOST_W'(acc_q[ACC_W-1:HOST_W]);
                else if (h_is_reg)         host_rdata = HOST_W'(rf_host_rd);
            end
            SP_IM:   host_rdata = HOST_W'(im_host_rd);
            SP_DM:   host_rdata = HOST_W'(dm_host_rd);
            default: host_rdata = '0;
        endcase
    end

    assert_res_follows_exec_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (running && x_res_valid) |=> res_valid);

    assert_idle_acc_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !h_acc_lo_wr && !h_acc_hi_wr) |=> $stable(acc_out));

    assert_no_result_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> !res_valid);

endmodule

// File: tb/tb_dsp_pe.sv
module tb_dsp_pe;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [11:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [39:0] chain_in = '0;
    logic [39:0] acc_out;
    logic        res_valid;
    logic [39:0] res_bus;
    logic        running;
    logic        done;
    logic        error;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    dsp_pe dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .chain_in(chain_in),
        .acc_out(acc_out), .res_valid(res_valid), .res_bus(res_bus),
        .running(running), .done(done), .error(error)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_im [1024];
    logic [15:0] m_dm [1024];
    logic [15:0] m_rf [8];
    logic [39:0] m_acc;
    int          m_pc;
    bit          m_run, m_done, m_err, m_rv;
    logic [39:0] m_res;

    function automatic logic [39:0] sx16(input logic [15:0] v);
        return {{24{v[15]}}, v};
    endfunction

    task automatic model_exec();
        logic [31:0] w;
        int op, ra, rb, rc, rd;
        logic [11:0] imm;
        longint p0, p1, a;
        w = m_im[m_pc];
        op = int'(w[31:24]); ra = int'(w[23:21]); rb = int'(w[20:18]);
        rc = int'(w[17:15]); rd = int'(w[14:12]); imm = w[11:0];
        p0 = longint'($signed(m_rf[ra])) * longint'($signed(m_rf[rb]));
        p1 = longint'($signed(m_rf[rc])) * longint'($signed(m_rf[rd]));
        m_rv = 1'b0;
        case (op)
            8'h00: ;
            8'h01: begin m_rf[ra] = m_rf[rb] + m_rf[rc]; m_rv = 1; m_res = sx16(m_rf[ra]); end
            8'h08: begin m_rf[ra] = {{4{imm[11]}}, imm}; m_rv = 1; m_res = sx16(m_rf[ra]); end
            8'h04: begin m_rf[ra] = m_dm[imm[9:0]]; m_rv = 1; m_res = sx16(m_rf[ra]); end
            8'h05: m_dm[imm[9:0]] = m_rf[ra];
            8'h06: begin
                a = longint'($signed(m_acc));
                if (a > 32767) m_rf[ra] = 16'h7FFF;
                else if (a < -32768) m_rf[ra] = 16'h8000;
                else m_rf[ra] = a[15:0];
                m_rv = 1; m_res = sx16(m_rf[ra]);
            end
            8'h02: begin m_acc = m_acc + 40'(p0) + 40'(p1); m_rv = 1; m_res = m_acc; end
            8'h03: begin m_acc = chain_in + 40'(p0); m_rv = 1; m_res = m_acc; end
            8'h07: begin m_acc = '0; m_rv = 1; m_res = m_acc; end
            8'hFF: begin m_run = 0; m_done = 1; end
            default: begin m_run = 0; m_err = 1; end
        endcase
        if (m_run && op != 8'hFF) m_pc = (m_pc + 1) % 1024;
    endtask

    task automatic chk(input string tag, input logic [39:0] got, input logic [39:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Step the model on each rising edge, then compare outputs off the edge.
    always @(posedge clk) begin
        bit was_run;
        int idx;
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) m_rf[i] = '0;
            m_acc = '0; m_pc = 0; m_run = 0; m_done = 0; m_err = 0; m_rv = 0; m_res = '0;
        end else begin
            was_run = m_run;
            idx = int'(host_addr[9:0]);
            if (was_run) model_exec(); else m_rv = 0;
            if (host_we && !was_run) begin
                case (host_addr[11:10])
                    2'd0: begin
                        if (idx == 2) m_acc[31:0] = host_wdata;
                        else if (idx == 3) m_acc[39:32] = host_wdata[7:0];
                        else if (idx >= 8 && idx < 16) m_rf[idx-8] = host_wdata[15:0];
                    end
                    2'd1: m_im[idx] = host_wdata;
                    2'd2: m_dm[idx] = host_wdata[15:0];
                    default: ;
                endcase
            end
            if (host_we && host_addr == 12'h000) begin
                if (host_wdata[0]) begin m_pc = 0; m_run = 1; m_done = 0; m_err = 0; end
                if (host_wdata[1]) m_run = 0;
            end
        end
        #3;
        chk("R11 acc_out", acc_out, m_acc);
        chk("R11 res_valid", 40'(res_valid), 40'(m_rv));
        if (m_rv) chk("R11 res_bus", res_bus, m_res);
        chk("R4 running", 40'(running), 40'(m_run));
        chk("R4 done", 40'(done), 40'(m_done));
        chk("R10 error", 40'(error), 40'(m_err));
    end

    // ---------------- host helpers ----------------
    task automatic hwrite(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hread(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        host_we = 1'b0; host_addr = a;
        #2;
        d = host_rdata;
    endtask

    task automatic hcheck(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        hread(a, d);
        chk(tag, 40'(d), 40'(exp));
    endtask

    function automatic logic [31:0] ins(input logic [7:0] op, input int ra, input int rb,
                                        input int rc, input int rd, input logic [11:0] imm);
        return {op, 3'(ra), 3'(rb), 3'(rc), 3'(rd), imm};
    endfunction

    task automatic run_to_stop();
        hwrite(12'h000, 32'h1);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (!running) break;
        end
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R4 watchdog actual=still_running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        hcheck("R1 status", 12'h000, 32'h0);
        hcheck("R1 pc", 12'h001, 32'h0);
        hcheck("R1 acc", 12'h002, 32'h0);
        for (int r = 0; r < 8; r++) hcheck("R1 reg", 12'(8 + r), 32'h0);
        chk("R1 res_valid", 40'(res_valid), 40'h0);

        // Clear both stores
        for (int i = 0; i < 1024; i++) begin
            hwrite(12'h400 | 12'(i), 32'h0);
            hwrite(12'h800 | 12'(i), 32'h0);
        end

        // R2: host access while halted
        hwrite(12'h00A, 32'h1234);
        hcheck("R2 reg r2", 12'h00A, 32'h1234);
        hwrite(12'h002, 32'h89ABCDEF);
        hwrite(12'h003, 32'h5A);
        hcheck("R2 acc lo", 12'h002, 32'h89ABCDEF);
        hcheck("R2 acc hi", 12'h003, 32'h5A);
        chk("R2 acc_out", acc_out, 40'h5A89ABCDEF);
        hwrite(12'h807, 32'hBEEF);
        hcheck("R2 dmem", 12'h807, 32'hBEEF);
        hwrite(12'h7E8, 32'hCAFEF00D);
        hcheck("R2 imem", 12'h7E8, 32'hCAFEF00D);
        hwrite(12'h7E8, 32'h0);

        // Program A: R5 R6 R8 R9
        hwrite(12'h400, ins(8'h08, 1, 0, 0, 0, 12'd300));
        hwrite(12'h401, ins(8'h08, 2, 0, 0, 0, 12'hFF9));
        hwrite(12'h402, ins(8'h01, 3, 1, 2, 0, 12'h0));
        hwrite(12'h403, ins(8'h07, 0, 0, 0, 0, 12'h0));
        hwrite(12'h404, ins(8'h02, 1, 2, 3, 1, 12'h0));
        hwrite(12'h405, ins(8'h06, 4, 0, 0, 0, 12'h0));
        hwrite(12'h406, ins(8'h05, 3, 0, 0, 0, 12'd5));
        hwrite(12'h407, ins(8'h04, 5, 0, 0, 0, 12'd5));
        hwrite(12'h408, ins(8'hFF, 0, 0, 0, 0, 12'h0));
        run_to_stop();
        hcheck("R4 status done", 12'h000, 32'h2);
        hcheck("R4 pc at halt", 12'h001, 32'd8);
        hcheck("R5 add", 12'h00B, 32'd293);
        hcheck("R5 ldi negative", 12'h00A, 32'hFFF9);
        hcheck("R6 dma acc lo", 12'h002, 32'd85800);
        hcheck("R6 dma acc hi", 12'h003, 32'h0);
        hcheck("R8 mva positive sat", 12'h00C, 32'h7FFF);
        hcheck("R9 st", 12'h805, 32'd293);
        hcheck("R9 ld", 12'h00D, 32'd293);

        // Program B: R7 chain MACC, negative saturation, ADD wrap
        chain_in = 40'hFFFFFE7960;  // -100000
        hwrite(12'h400, ins(8'h08, 1, 0, 0, 0, 12'h7FF));
        hwrite(12'h401, ins(8'h08, 2, 0, 0, 0, 12'h800));
        hwrite(12'h402, ins(8'h03, 1, 2, 0, 0, 12'h0));
        hwrite(12'h403, ins(8'h06, 6, 0, 0, 0, 12'h0));
        hwrite(12'h404, ins(8'h03, 1, 1, 0, 0, 12'h0));
        hwrite(12'h405, ins(8'h06, 7, 0, 0, 0, 12'h0));
        hwrite(12'h406, ins(8'h08, 0, 0, 0, 0, 12'h1));
        hwrite(12'h407, ins(8'h01, 5, 7, 0, 0, 12'h0));
        hwrite(12'h408, ins(8'hFF, 0, 0, 0, 0, 12'h0));
        run_to_stop();
        hcheck("R8 mva negative sat", 12'h00E, 32'h8000);
        hcheck("R8 mva positive sat", 12'h00F, 32'h7FFF);
        hcheck("R7 macc acc lo", 12'h002, 32'd4090209);
        chk("R11 acc_out chain value", acc_out, 40'd4090209);
        hcheck("R5 add wrap", 12'h00D, 32'h8000);

        // Program C: R10 undefined opcode
        hwrite(12'h400, 32'h0);
        hwrite(12'h401, ins(8'h55, 0, 0, 0, 0, 12'h0));
        run_to_stop();
        hcheck("R10 status error only", 12'h000, 32'h4);
        hcheck("R10 pc at bad op", 12'h001, 32'd1);

        // Program D: R3 ignored host writes, R12 stop
        hwrite(12'h400, ins(8'h08, 1, 0, 0, 0, 12'd5));
        for (int i = 1; i < 9; i++) hwrite(12'h400 | 12'(i), 32'h0);
        hwrite(12'h000, 32'h1);
        hcheck("R10 error cleared by start", 12'h000, 32'h1);
        hwrite(12'h009, 32'd77);
        hwrite(12'h809, 32'd1234);
        hwrite(12'h002, 32'h0);
        hwrite(12'h000, 32'h2);
        hcheck("R12 stopped not done", 12'h000, 32'h0);
        hcheck("R3 reg write ignored", 12'h009, 32'd5);
        hcheck("R3 dmem write ignored", 12'h809, 32'h0);
        hcheck("R3 acc write ignored", 12'h002, 32'd4090209);

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule